// File: doc/BRIEF.md
# Two-Phase Pulse Steering Unit

This block accepts a single pulse-width-modulated stream and hands its pulses out in turn to two drive outputs, phase A and phase B, for a push-pull transformer stage. Each output therefore switches at half the input rate, the two outputs sit half a switching period apart, and each output pulse is exactly as wide as the input pulse it came from. Equal on-time on both sides keeps the average transformer current at zero.

The input is brought into the clock domain through a synchroniser chain; its edges are then detected in that domain. A selection flop decides which output gets the next pulse and changes only once a pulse has ended, so no pulse is ever cut short or moved to the other output partway through. Dropping the enable lets a running pulse finish, then keeps both outputs low and points the selection back at phase A.

Top module: `pwm_steer_top`

## Requirements
- R1: After reset, the first steered pulse appears on phase A, and while enable stays high, later pulses alternate B, A, B, and so on.
- R2: Every output pulse is high for exactly as many clock cycles as the input pulse it came from.
- R3: Phase A and phase B are never high in the same cycle.
- R4: While enable is low and no pulse is in progress, both outputs stay low, input pulses produce no output, and the next pulse after enable returns goes to phase A.
- R5: If enable falls while an output pulse is in progress, that pulse still completes at its full width.
- R6: While rst_n is low, both outputs are low, and the first pulse after reset goes to phase A.
- R7: An output rises exactly SYNC_STAGES+1 clock cycles after the input rise it follows, and falls the same number of cycles after the input fall (3 cycles with the default of 2 stages).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Single-phase pulse stream, asynchronous to clk |
| en | input | 1 | Steering enable, synchronous to clk |
| phase_a_o | output | 1 | Phase A drive, active high |
| phase_b_o | output | 1 | Phase B drive, active high |

## Verification
Pulse widths from one to eight cycles are swept against gaps from three to five cycles. This separates a correct width copy from an off-by-one at either edge, and shows whether alternation survives both short and long pulses. Pulses sent while the block is disabled, a disable asserted partway through a phase B pulse, and a reset between pulses each show whether the selection returns to phase A and whether a running pulse is cut short. Overlap and the rise latency are counted on every pulse.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

    typedef struct packed {
        logic sel;     // 0: next pulse to phase A, 1: to phase B
        logic active;  // a pulse is being passed through
        logic drv_a;
        logic drv_b;
    } steer_state_t;

    localparam steer_state_t STEER_IDLE = '{sel: 1'b0, active: 1'b0, drv_a: 1'b0, drv_b: 1'b0};

endpackage

// File: rtl/pwm_edge_sync.sv
module pwm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
        prev_d = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/pwm_steer_fsm.sv
module pwm_steer_fsm
    import pwm_steer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rise_i,
    input  logic fall_i,
    output logic drv_a_o,
    output logic drv_b_o
);
    steer_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            // Pulse in flight: only its own falling edge ends it.
            if (fall_i) begin
                st_d.active = 1'b0;
                st_d.drv_a  = 1'b0;
                st_d.drv_b  = 1'b0;
                st_d.sel    = en ? ~st_q.sel : 1'b0;
            end
        end else if (!en) begin
            st_d.sel = 1'b0;
        end else if (rise_i) begin
            st_d.active = 1'b1;
            st_d.drv_a  = ~st_q.sel;
            st_d.drv_b  = st_q.sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= STEER_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign drv_a_o = st_q.drv_a;
    assign drv_b_o = st_q.drv_b;

endmodule

// File: rtl/pwm_steer_top.sv
module pwm_steer_top #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    input  logic en,
    output logic phase_a_o,
    output logic phase_b_o
);
    logic pwm_level;
    logic pwm_rise;
    logic pwm_fall;

    pwm_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pwm_in),
        .level_o  (pwm_level),
        .rise_o   (pwm_rise),
        .fall_o   (pwm_fall)
    );

    pwm_steer_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .rise_i  (pwm_rise),
        .fall_i  (pwm_fall),
        .drv_a_o (phase_a_o),
        .drv_b_o (phase_b_o)
    );

    logic unused_level;
    assign unused_level = pwm_level;

endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk #(
    parameter int LAT = 3
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic pwm_in,
    input logic phase_a,
    input logic phase_b
);
    // Set when the latest completed pulse was on phase A.
    logic last_was_a_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_was_a_q <= 1'b0;
        end else if (!phase_a && $past(phase_a)) begin
            last_was_a_q <= 1'b1;
        end else if (!phase_b && $past(phase_b)) begin
            last_was_a_q <= 1'b0;
        end
    end

    // R3
    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase_a && phase_b));

    // R1: a phase B pulse only ever follows a completed phase A pulse
    a_r1_b_follows_a: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_b) |-> last_was_a_q);

    // R4
    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !phase_a && !phase_b) |=> (!phase_a && !phase_b));

    // R5: a running pulse continues while its delayed input is still high
    a_r5_a_not_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_a && $past(pwm_in, LAT-1)) |=> phase_a);
    a_r5_b_not_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_b && $past(pwm_in, LAT-1)) |=> phase_b);

    // R7
    a_r7_a_rise_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_a) |-> $past(pwm_in, LAT));
    a_r7_b_rise_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_b) |-> $past(pwm_in, LAT));
    // R2 / R7: falls follow the input fall by the same latency
    a_r2_a_fall_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phase_a) |-> !$past(pwm_in, LAT));
    a_r2_b_fall_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phase_b) |-> !$past(pwm_in, LAT));

    // R6
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r6_reset_low: assert (!phase_a && !phase_b);
        end
    end

endmodule

bind pwm_steer_top pwm_steer_chk #(
    .LAT (SYNC_STAGES + 1)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .pwm_in  (pwm_in),
    .phase_a (phase_a_o),
    .phase_b (phase_b_o)
);

// File: tb/pwm_steer_top_tb_top.sv
module pwm_steer_top_tb_top;
    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_in = 1'b0;
    logic en = 1'b0;
    logic phase_a_o, phase_b_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit exp_sel = 1'b0;   // bench model: 0 -> next pulse to A

    always #4 clk = ~clk;

    pwm_steer_top #(.SYNC_STAGES(SYNC)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_in    (pwm_in),
        .en        (en),
        .phase_a_o (phase_a_o),
        .phase_b_o (phase_b_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Send one pulse of hi cycles followed by lo cycles (lo >= 3).
    // drop_at >= 0 lowers en at that cycle index of the window.
    // want: 0 = phase A, 1 = phase B, 2 = no output.
    task automatic send_pulse(input int hi, input int lo, input int drop_at, input int want,
                              input string req);
        int cnt_a = 0;
        int cnt_b = 0;
        int both = 0;
        int first = -1;
        for (int i = 0; i < hi + lo; i++) begin
            pwm_in = (i < hi);
            if (i == drop_at) en = 1'b0;
            @(posedge clk);
            @(negedge clk);
            if (phase_a_o) cnt_a++;
            if (phase_b_o) cnt_b++;
            if (phase_a_o && phase_b_o) both++;
            if ((phase_a_o || phase_b_o) && first < 0) first = i + 1;
        end
        check(both == 0, "R3 overlap cycles", both, 0);
        if (want == 2) begin
            check(cnt_a + cnt_b == 0, {req, " no output"}, cnt_a + cnt_b, 0);
        end else begin
            check((want == 0 ? cnt_a : cnt_b) == hi, {req, " R2 width on selected phase"},
                  (want == 0 ? cnt_a : cnt_b), hi);
            check((want == 0 ? cnt_b : cnt_a) == 0, {req, " R1 other phase quiet"},
                  (want == 0 ? cnt_b : cnt_a), 0);
            check(first == LAT, "R7 rise latency", first, LAT);
        end
    endtask

    // Pulse with en high at its start; model follows the alternation.
    task automatic steered(input int hi, input int lo, input string req);
        send_pulse(hi, lo, -1, exp_sel ? 1 : 0, req);
        exp_sel = ~exp_sel;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R6: outputs low in reset, even with input activity
        pwm_in = 1'b1;
        en = 1'b1;
        repeat (4) @(negedge clk);
        check(!phase_a_o && !phase_b_o, "R6 outputs low in reset", {phase_a_o, phase_b_o}, 0);
        pwm_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R7 sweep: widths 1..8 against gaps 3..5
        for (int lo = 3; lo <= 5; lo++) begin
            for (int hi = 1; hi <= 8; hi++) begin
                steered(hi, lo, "R1 sweep");
            end
        end

        // R4: disabled pulses ignored, selection returns to A
        if (exp_sel == 1'b0) steered(3, 4, "R1 align");
        // exp_sel now 1 (next would be B)
        en = 1'b0;
        repeat (2) @(negedge clk);
        send_pulse(4, 4, -1, 2, "R4 disabled");
        send_pulse(1, 3, -1, 2, "R4 disabled short");
        en = 1'b1;
        exp_sel = 1'b0;
        steered(5, 4, "R4 return to A");

        // R5: disable during a phase B pulse, pulse completes
        send_pulse(6, 4, 3, 1, "R5 drop mid B pulse");
        check(!phase_a_o && !phase_b_o, "R5 outputs low after drop", {phase_a_o, phase_b_o}, 0);
        send_pulse(3, 4, -1, 2, "R5 still disabled");
        en = 1'b1;
        exp_sel = 1'b0;
        steered(2, 4, "R5 resume on A");

        // R6: reset between pulses returns selection to A
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!phase_a_o && !phase_b_o, "R6 reset mid run", {phase_a_o, phase_b_o}, 0);
        rst_n = 1'b1;
        exp_sel = 1'b0;
        repeat (2) @(negedge clk);
        steered(4, 3, "R6 first after reset on A");
        steered(4, 3, "R6 second on B");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule